// File: doc/BRIEF.md
# Interleaved Clamped Space-Vector PWM Generator

This block drives the six gates of a two-level three-phase bridge. Once per switching period it takes a sector code and two active-state dwell times, which an upstream controller derives from the stationary-frame voltage command. It builds a discontinuous pattern with 60-degree clamping. In each sector only one zero state is used, and it alternates from sector to sector between all upper switches on and all lower switches on. As a result, the phase with the largest magnitude in that sector does not switch for the whole sector.

A free-running carrier counter sets the period. A shared sync pulse reloads the counter. Depending on the `lag_half` pin, the reload puts the module's period boundary either on the sync or half a period later. Two copies of the block on the same sync pulse can therefore switch 180 degrees apart. The command is captured only when the carrier wraps, so sector changes and dwell updates never land inside a period. Each lower gate is the complement of its upper gate, with a fixed dead band inserted on every edge.

Top module: `svpwm_interleaved_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, all six gate outputs are low.
- R2: The carrier counts 0 to PERIOD_CYC-1 and wraps. When `sync` is high, the next count is 0 if `lag_half` is 0 and PERIOD_CYC/2 if `lag_half` is 1. The lagging setting therefore moves every period boundary, and every switching edge, PERIOD_CYC/2 cycles later.
- R3: Sector and dwells are captured only on the clock where the next carrier value is 0. A change applied mid-period has no effect on the gates until the following period.
- R4: Switching states are written as (a,b,c) with 1 meaning the upper switch is on. Sector s in 0..5 uses states S(s+1) and S(s+2), with S7 wrapping to S1. The states are S1=(1,0,0), S2=(1,1,0), S3=(0,1,0), S4=(0,1,1), S5=(0,0,1) and S6=(1,0,1). `dwell_a` applies to the first state and `dwell_b` to the second. Each phase duty is the sum of the dwells of the states in which that phase is on, plus the zero time if the zero state is all-upper.
- R5: Even sectors use only the all-upper zero state and odd sectors only the all-lower one, so in every sector one phase's upper gate (even) or lower gate (odd) stays on for the whole period.
- R6: If `dwell_a` exceeds PERIOD_CYC it is limited to PERIOD_CYC. `dwell_b` is then limited to PERIOD_CYC minus the limited `dwell_a`. The zero time is whatever remains and is never negative.
- R7: Sector codes 6 and 7 are ignored at capture. The previous sector and both previous dwells are kept.
- R8: A phase's upper demand is high for carrier values below its duty. The upper gate rises DEAD_CYC+1 clocks after the carrier reaches 0.
- R9: The upper and lower gates of a phase are never high together. After each demand change, both stay low for exactly DEAD_CYC clocks (DEAD_CYC of at least 1). A duty of 0 or PERIOD_CYC produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Shared carrier reload pulse |
| lag_half | input | 1 | 1: reload to half period (interleaved partner) |
| sector_in | input | 3 | Sector code 0..5 |
| dwell_a | input | CNT_W | Dwell of the first active state, clocks |
| dwell_b | input | CNT_W | Dwell of the second active state, clocks |
| gate_top | output | 3 | Upper gate drives, bit0 = phase a |
| gate_bot | output | 3 | Lower gate drives, bit0 = phase a |

## Verification
A wrong carrier phase or a bad sync reload shows up within one period as switching edges that move by a whole number of clocks relative to the sync pulse. A wrong sector latch or a wrong state table shows up one period after capture as per-period upper-on and lower-on counts that differ from the dwell sums. A wrong zero-state choice shows up at the same point, and also as a phase that should be clamped but switches. A dead-band fault shows up at the very next edge, as an overlap or as a gap that is too short or too long. A capture that happens at the wrong moment shows up inside the period in which the command changes.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;
  localparam int unsigned NUM_PHASES  = 3;
  localparam int unsigned NUM_SECTORS = 6;

  typedef logic [2:0] sector_t;

  // Bridge switching state: bit0 phase a, bit1 phase b, bit2 phase c upper on.
  function automatic logic [2:0] state_bits(input logic [2:0] idx);
    logic [2:0] bits;
    case (idx)
      3'd1:    bits = 3'b001;
      3'd2:    bits = 3'b011;
      3'd3:    bits = 3'b010;
      3'd4:    bits = 3'b110;
      3'd5:    bits = 3'b100;
      3'd6:    bits = 3'b101;
      default: bits = 3'b000;
    endcase
    return bits;
  endfunction

  function automatic logic [2:0] lead_state(input sector_t s);
    return s + 3'd1;
  endfunction

  function automatic logic [2:0] trail_state(input sector_t s);
    return (s == 3'd5) ? 3'd1 : s + 3'd2;
  endfunction

  // Even sectors free-wheel on the all-upper state.
  function automatic logic upper_zero(input sector_t s);
    return ~s[0];
  endfunction

  function automatic logic sector_legal(input sector_t s);
    return s < sector_t'(NUM_SECTORS);
  endfunction
endpackage

// File: rtl/svpwm_carrier.sv
module svpwm_carrier #(
  parameter int unsigned PERIOD_CYC = 10000,
  parameter int unsigned CNT_W      = $clog2(PERIOD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic             lag_half,
  output logic [CNT_W-1:0] cnt,
  output logic             load
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(PERIOD_CYC / 2);

  // Next count is zero: the capture point of the command.
  assign load = sync ? ~lag_half : (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (sync)        cnt <= lag_half ? HALF : '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  p_range_r2: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sync) && $past(cnt) != LAST) |-> cnt == $past(cnt) + 1'b1);

  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sync)) |-> cnt == ($past(lag_half) ? HALF : '0));
endmodule

// File: rtl/svpwm_cmd_latch.sv
module svpwm_cmd_latch
  import svpwm_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 10000,
  parameter int unsigned CNT_W      = $clog2(PERIOD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  sector_t          sector_in,
  input  logic [CNT_W-1:0] dwell_a,
  input  logic [CNT_W-1:0] dwell_b,
  output sector_t          sec_q,
  output logic [CNT_W-1:0] ta_q,
  output logic [CNT_W-1:0] tb_q,
  output logic [CNT_W-1:0] t0_q
);
  localparam logic [CNT_W-1:0] PMAX = CNT_W'(PERIOD_CYC);

  logic [CNT_W-1:0] ta_lim, tb_room, tb_lim;

  always_comb begin
    ta_lim  = (dwell_a > PMAX) ? PMAX : dwell_a;
    tb_room = PMAX - ta_lim;
    tb_lim  = (dwell_b > tb_room) ? tb_room : dwell_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      ta_q  <= '0;
      tb_q  <= '0;
      t0_q  <= PMAX;
    end else if (load && sector_legal(sector_in)) begin
      sec_q <= sector_in;
      ta_q  <= ta_lim;
      tb_q  <= tb_lim;
      t0_q  <= tb_room - tb_lim;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> $stable({sec_q, ta_q, tb_q, t0_q}));

  p_sector_legal_r7: assert property (@(posedge clk) disable iff (rst)
    sec_q < sector_t'(NUM_SECTORS));

  p_budget_r6: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, ta_q} + {1'b0, tb_q} + {1'b0, t0_q}) == {1'b0, PMAX});
endmodule

// File: rtl/svpwm_duty_map.sv
module svpwm_duty_map
  import svpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  sector_t                          sec,
  input  logic [CNT_W-1:0]                 ta,
  input  logic [CNT_W-1:0]                 tb,
  input  logic [CNT_W-1:0]                 t0,
  output logic [NUM_PHASES-1:0][CNT_W-1:0] duty
);
  logic [2:0] bits_a, bits_b;
  logic       zero_up;

  assign bits_a  = state_bits(lead_state(sec));
  assign bits_b  = state_bits(trail_state(sec));
  assign zero_up = upper_zero(sec);

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    assign duty[p] = (bits_a[p] ? ta : '0)
                   + (bits_b[p] ? tb : '0)
                   + (zero_up   ? t0 : '0);
  end
endmodule

// File: rtl/svpwm_deadband.sv
module svpwm_deadband #(
  parameter int unsigned DEAD_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic demand,
  output logic hi,
  output logic lo
);
  localparam int unsigned DW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [DW-1:0] RELOAD = DW'(DEAD_CYC - 1);

  logic          dem_q;
  logic [DW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dem_q  <= 1'b0;
      wait_q <= '0;
      hi     <= 1'b0;
      lo     <= 1'b0;
    end else if (demand != dem_q) begin
      dem_q  <= demand;
      wait_q <= RELOAD;
      hi     <= 1'b0;
      lo     <= 1'b0;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
      hi     <= 1'b0;
      lo     <= 1'b0;
    end else begin
      hi     <= dem_q;
      lo     <= ~dem_q;
    end
  end

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst) !(hi && lo));

  p_hi_after_gap_r9: assert property (@(posedge clk) disable iff (rst)
    (hi && !$past(hi)) |-> !$past(lo));

  p_lo_after_gap_r9: assert property (@(posedge clk) disable iff (rst)
    (lo && !$past(lo)) |-> !$past(hi));
endmodule

// File: rtl/svpwm_interleaved_gen.sv
module svpwm_interleaved_gen
  import svpwm_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 10000,
  parameter int unsigned DEAD_CYC   = 100,
  parameter int unsigned CNT_W      = $clog2(PERIOD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic             lag_half,
  input  logic [2:0]       sector_in,
  input  logic [CNT_W-1:0] dwell_a,
  input  logic [CNT_W-1:0] dwell_b,
  output logic [2:0]       gate_top,
  output logic [2:0]       gate_bot
);
  localparam logic [CNT_W-1:0] PMAX = CNT_W'(PERIOD_CYC);

  logic [CNT_W-1:0]                 cnt;
  logic                             load;
  sector_t                          sec_q;
  logic [CNT_W-1:0]                 ta_q, tb_q, t0_q;
  logic [NUM_PHASES-1:0][CNT_W-1:0] duty;
  logic [NUM_PHASES-1:0]            demand;

  svpwm_carrier #(.PERIOD_CYC(PERIOD_CYC), .CNT_W(CNT_W)) u_carrier (
    .clk(clk), .rst(rst), .sync(sync), .lag_half(lag_half),
    .cnt(cnt), .load(load)
  );

  svpwm_cmd_latch #(.PERIOD_CYC(PERIOD_CYC), .CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst(rst), .load(load), .sector_in(sector_in),
    .dwell_a(dwell_a), .dwell_b(dwell_b),
    .sec_q(sec_q), .ta_q(ta_q), .tb_q(tb_q), .t0_q(t0_q)
  );

  svpwm_duty_map #(.CNT_W(CNT_W)) u_map (
    .sec(sec_q), .ta(ta_q), .tb(tb_q), .t0(t0_q), .duty(duty)
  );

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
    assign demand[p] = cnt < duty[p];

    svpwm_deadband #(.DEAD_CYC(DEAD_CYC)) u_db (
      .clk(clk), .rst(rst), .demand(demand[p]),
      .hi(gate_top[p]), .lo(gate_bot[p])
    );
  end

  p_clamp_up_r5: assert property (@(posedge clk) disable iff (rst)
    !sec_q[0] |-> (duty[0] == PMAX || duty[1] == PMAX || duty[2] == PMAX));

  p_clamp_dn_r5: assert property (@(posedge clk) disable iff (rst)
    sec_q[0] |-> (duty[0] == '0 || duty[1] == '0 || duty[2] == '0));

  p_duty_bound_r4: assert property (@(posedge clk) disable iff (rst)
    duty[0] <= PMAX && duty[1] <= PMAX && duty[2] <= PMAX);
endmodule

// File: tb/svpwm_interleaved_gen_test.sv
module svpwm_interleaved_gen_test;
  localparam int P  = 40;
  localparam int DT = 2;
  localparam int W  = $clog2(P + 1);

  typedef struct packed {
    logic [2:0] s;
    int da; int db;
    int ea; int eb; int ec;
    logic zup;
    int tag;
  } vec_t;

  // tag: 4 = state mapping, 6 = saturation, 7 = illegal sector
  localparam vec_t TBL [0:7] = '{
    '{3'd0, 10,  6, 40, 30, 24, 1'b1, 4},
    '{3'd1, 12,  8, 12, 20,  0, 1'b0, 4},
    '{3'd2,  5, 15, 20, 40, 35, 1'b1, 4},
    '{3'd3, 14,  4,  0, 14, 18, 1'b0, 4},
    '{3'd4,  8,  8, 32, 24, 40, 1'b1, 4},
    '{3'd5,  9, 11, 20,  0,  9, 1'b0, 4},
    '{3'd0, 30, 20, 40, 10,  0, 1'b1, 6},
    '{3'd6,  5,  5, 40, 10,  0, 1'b1, 7}
  };

  logic clk = 1'b0, rst = 1'b1, sync = 1'b0, lag = 1'b0;
  logic [2:0] sec = '0;
  logic [W-1:0] da = '0, db = '0;
  logic [2:0] top, bot;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  svpwm_interleaved_gen #(.PERIOD_CYC(P), .DEAD_CYC(DT), .CNT_W(W)) uut (
    .clk(clk), .rst(rst), .sync(sync), .lag_half(lag),
    .sector_in(sec), .dwell_a(da), .dwell_b(db),
    .gate_top(top), .gate_bot(bot)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_top(input int d);
    return (d == 0) ? 0 : (d == P) ? P : d - DT;
  endfunction

  function automatic int exp_bot(input int d);
    return (d == 0) ? P : (d == P) ? 0 : P - d - DT;
  endfunction

  task automatic drive(input logic [2:0] s, input int a, input int b);
    @(negedge clk);
    sec = s; da = W'(a); db = W'(b);
  endtask

  task automatic sync_pulse(input logic l);
    @(negedge clk); sync = 1'b1; lag = l;
    @(negedge clk); sync = 1'b0;
  endtask

  task automatic first_rise_after(input int from, output int at);
    logic prev;
    at = -1;
    prev = top[2];
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk);
      if (k > from && top[2] && !prev && at < 0) at = k;
      prev = top[2];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int tc[3], bc[3], ov, rise;
    bit ok;
    string rq;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(top == 3'b000 && bot == 3'b000, "R1", "gates in reset", {top, bot}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(top == 3'b000 && bot == 3'b000, "R1", "gates after reset", {top, bot}, 0);

    sync_pulse(1'b0);

    for (int i = 0; i < 8; i++) begin
      drive(TBL[i].s, TBL[i].da, TBL[i].db);
      repeat (2 * P) @(negedge clk);
      for (int p = 0; p < 3; p++) begin tc[p] = 0; bc[p] = 0; end
      ov = 0;
      for (int k = 0; k < P; k++) begin
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
          tc[p] += int'(top[p]);
          bc[p] += int'(bot[p]);
          if (top[p] && bot[p]) ov++;
        end
      end
      rq = (TBL[i].tag == 6) ? "R6" : (TBL[i].tag == 7) ? "R7" : "R4";
      check(tc[0] == exp_top(TBL[i].ea), rq, "phase a upper count", tc[0], exp_top(TBL[i].ea));
      check(tc[1] == exp_top(TBL[i].eb), rq, "phase b upper count", tc[1], exp_top(TBL[i].eb));
      check(tc[2] == exp_top(TBL[i].ec), rq, "phase c upper count", tc[2], exp_top(TBL[i].ec));
      check(bc[0] == exp_bot(TBL[i].ea), rq, "phase a lower count", bc[0], exp_bot(TBL[i].ea));
      check(bc[1] == exp_bot(TBL[i].eb), rq, "phase b lower count", bc[1], exp_bot(TBL[i].eb));
      check(bc[2] == exp_bot(TBL[i].ec), rq, "phase c lower count", bc[2], exp_bot(TBL[i].ec));
      check(ov == 0, "R9", "upper/lower overlap cycles", ov, 0);
      if (TBL[i].zup)
        ok = (tc[0] == P) || (tc[1] == P) || (tc[2] == P);
      else
        ok = (bc[0] == P) || (bc[1] == P) || (bc[2] == P);
      check(ok, "R5", "clamped phase held", int'(ok), 1);
    end

    // R3: a command change mid-period waits for the wrap
    drive(3'd0, 10, 6);
    repeat (2 * P) @(negedge clk);
    sync_pulse(1'b0);
    repeat (10) @(negedge clk);
    sec = 3'd3; da = W'(14); db = W'(4);
    ok = 1'b1;
    for (int k = 11; k <= 40; k++) begin
      @(negedge clk);
      if (top[0] !== 1'b1) ok = 1'b0;
    end
    check(ok, "R3", "phase a upper held through period", int'(ok), 1);
    repeat (5) @(negedge clk);
    check(top[0] == 1'b0 && bot[0] == 1'b1, "R3", "new command after wrap",
          {top[0], bot[0]}, 1);

    // R8 / R2: edge placement and half-period interleave
    drive(3'd0, 10, 6);
    repeat (2 * P) @(negedge clk);
    sync_pulse(1'b0);
    first_rise_after(30, rise);
    check(rise == P + DT + 1, "R8", "phase c rise index, leading", rise, P + DT + 1);
    sync_pulse(1'b1);
    first_rise_after(30, rise);
    check(rise == P + P / 2 + DT + 1, "R2", "phase c rise index, lagging", rise, P + P / 2 + DT + 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule